// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the reset a processor sees. It combines two causes: a supply-low flag from an external comparator and an active-low pushbutton. Either cause drives reset active within a few clock cycles. After the last cause goes away, reset stays active for a long, fixed hold time. The hold count starts when a cause is released, not when it first appears. If a new cause arrives while the hold is still running, reset stays active and the count starts over once that cause clears.

Both inputs are asynchronous. Each passes through a two-stage synchronizer and then a stability filter. The supply flag must stay low-going for a short run of cycles, so brief dips on the supply do not cause a reset. The pushbutton must stay stable for a longer run of cycles before a press is accepted, and stable again before a release is accepted. Reset is driven out on two pins of opposite polarity, and each pin has its own flop.

All time constants are cycle-count parameters. Their defaults are computed from the clock frequency: a 205 ms hold, a 4 µs supply filter, and 10 ms for button press and release. The block has no data stream, so every pin is a plain control level.

Top module: `reset_supervisor`

## Requirements
- R1: `rst_out_n` is always the inverse of `rst_out` (reset active means `rst_out`=1 and `rst_out_n`=0).
- R2: While `por_n` is low, `rst_out`=1. After `por_n` rises with the inputs idle (`supply_low`=0, `btn_n`=1), `rst_out` stays 1 at the first HOLD_CYC-1 rising edges and is 0 after rising edge HOLD_CYC.
- R3: A `supply_low`=1 pulse lasting fewer than SUP_SET_CYC rising edges leaves `rst_out` at 0.
- R4: If `supply_low`=1 lasts at least SUP_SET_CYC edges, `rst_out` becomes 1 at rising edge SUP_SET_CYC+3, counted from the change.
- R5: `btn_n` is active low. A press (`btn_n`=0) lasting at least PB_PRESS_CYC edges makes `rst_out` 1 at edge PB_PRESS_CYC+3. A shorter press leaves `rst_out` at 0.
- R6: If a cause is active for L edges, `rst_out` returns to 0 at edge L+2+C+HOLD_CYC, counted from its onset. C is SUP_CLR_CYC for the supply and PB_RELEASE_CYC for the button. The hold therefore counts from release.
- R7: Inside a press, high runs on `btn_n` shorter than PB_RELEASE_CYC edges are not taken as a release. The hold counts from the last low edge.
- R8: A new accepted cause during the hold keeps `rst_out` at 1 without a gap. Deassertion then follows R6, counted from the new cause.
- R9: When both causes overlap, `rst_out` stays 1 until the cause that releases last has run its R6 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low | input | 1 | Comparator flag, 1 = main supply below tolerance (asynchronous) |
| btn_n | input | 1 | Pushbutton, 0 = pressed (asynchronous) |
| rst_out | output | 1 | Reset to processor, active high |
| rst_out_n | output | 1 | Reset to processor, active low |

## Verification
A wrong filter counter shows up at the ports as a reset edge that arrives a cycle early or late, or as a glitch that causes a reset. The first of these is visible within SUP_SET_CYC+3 or PB_PRESS_CYC+3 edges. A hold counter that starts at the wrong point, or does not restart, moves the falling edge of `rst_out` away from L+2+C+HOLD_CYC. So the bench compares the exact edge index of every rise and fall, not just the level. A broken output pair shows immediately as two equal levels on `rst_out` and `rst_out_n`.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  // Convert a duration in microseconds to clock cycles, rounding up.
  function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned us);
    longint unsigned prod;
    prod = clk_hz * us;
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  // One bit per reset cause, after synchronizing.
  typedef struct packed {
    logic supply;
    logic button;
  } cause_t;

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stage_q[s] <= '0;
          else         stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stage_q[s] <= '0;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rsup_filter.sv
module rsup_filter #(
  parameter int unsigned SET_CYC = 4,
  parameter int unsigned CLR_CYC = 1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic raw_i,
  output logic filt_o
);

  localparam int unsigned MAXC = (SET_CYC > CLR_CYC) ? SET_CYC : CLR_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SET_CYC - 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CYC - 1);

  logic [CW-1:0] run_q, run_d;
  logic          filt_q, filt_d;
  logic [CW-1:0] limit;

  always_comb begin
    limit  = filt_q ? CLR_LAST : SET_LAST;
    filt_d = filt_q;
    run_d  = '0;
    if (raw_i != filt_q) begin
      if (run_q == limit) begin
        filt_d = raw_i;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else begin
      filt_q <= filt_d;
      run_q  <= run_d;
    end
  end

  assign filt_o = filt_q;

  // R3 R5 R7: the filtered level only moves toward a level the raw input held
  assert_filtered_change_R3: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(filt_q) |-> ($past(raw_i) == filt_q));

endmodule

// File: rtl/rsup_hold.sv
module rsup_hold #(
  parameter int unsigned HOLD_CYC = 205000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cause_i,
  output logic act_o,
  output logic act_n_o
);

  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d, act_n_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (cause_i) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      act_q   <= 1'b1;
      act_n_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      act_q   <= act_d;
      act_n_q <= !act_d;
      cnt_q   <= cnt_d;
    end
  end

  assign act_o   = act_q;
  assign act_n_o = act_n_q;

  // R4: an accepted cause forces reset on the next edge
  assert_cause_sets_R4: assert property (@(posedge clk) disable iff (!arst_n)
    cause_i |=> act_q);

  // R6: reset never drops before the hold count is used up
  assert_no_early_release_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (act_q && (cnt_q != LAST)) |=> act_q);

  // R8: a cause during the hold restarts the count
  assert_restart_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (act_q && cause_i) |=> (cnt_q == '0));

endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import rsup_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 1_000_000,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned HOLD_CYC       = us_to_cycles(CLK_HZ, 205000),
  parameter int unsigned SUP_SET_CYC    = us_to_cycles(CLK_HZ, 4),
  parameter int unsigned SUP_CLR_CYC    = 2,
  parameter int unsigned PB_PRESS_CYC   = us_to_cycles(CLK_HZ, 10000),
  parameter int unsigned PB_RELEASE_CYC = us_to_cycles(CLK_HZ, 10000)
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_low,
  input  logic btn_n,
  output logic rst_out,
  output logic rst_out_n
);

  cause_t raw_c, sync_c, filt_c;

  assign raw_c.supply = supply_low;
  assign raw_c.button = !btn_n;

  rsup_sync #(
    .WIDTH  ($bits(cause_t)),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .async_i (raw_c),
    .sync_o  (sync_c)
  );

  rsup_filter #(
    .SET_CYC (SUP_SET_CYC),
    .CLR_CYC (SUP_CLR_CYC)
  ) u_sup_filt (
    .clk    (clk),
    .arst_n (por_n),
    .raw_i  (sync_c.supply),
    .filt_o (filt_c.supply)
  );

  rsup_filter #(
    .SET_CYC (PB_PRESS_CYC),
    .CLR_CYC (PB_RELEASE_CYC)
  ) u_pb_filt (
    .clk    (clk),
    .arst_n (por_n),
    .raw_i  (sync_c.button),
    .filt_o (filt_c.button)
  );

  rsup_hold #(
    .HOLD_CYC (HOLD_CYC)
  ) u_hold (
    .clk     (clk),
    .arst_n  (por_n),
    .cause_i (filt_c.supply | filt_c.button),
    .act_o   (rst_out),
    .act_n_o (rst_out_n)
  );

  // R1: the two output flops always carry opposite levels
  assert_complement_R1: assert property (@(posedge clk) disable iff (!por_n)
    rst_out == !rst_out_n);

endmodule

// File: tb/sim_reset_supervisor.sv
module sim_reset_supervisor;

  localparam time CLK_PERIOD = 10ns;
  localparam int HOLD = 40;
  localparam int SN = 4;   // supply set
  localparam int SM = 2;   // supply clear
  localparam int PN = 5;   // button press
  localparam int PM = 6;   // button release

  typedef struct packed {
    int sup_len;
    int pb_len;
    int exp_rise;
    int exp_fall;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3,  0, 0,    0},                     // R3 short supply dip
    '{4,  0, 3+SN, 4+2+SM+HOLD},           // R4 R6 minimum supply
    '{10, 0, 3+SN, 10+2+SM+HOLD},          // R4 R6
    '{0,  4, 0,    0},                     // R5 short press
    '{0,  5, 3+PN, 5+2+PM+HOLD},           // R5 R6 minimum press
    '{0, 20, 3+PN, 20+2+PM+HOLD},          // R5 R6 long press
    '{1,  0, 0,    0},                     // R3 single-cycle dip
    '{0,  1, 0,    0}                      // R5 single-cycle press
  };

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_low = 1'b0;
  logic btn_n = 1'b1;
  logic rst_out, rst_out_n;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_supervisor #(
    .HOLD_CYC       (HOLD),
    .SUP_SET_CYC    (SN),
    .SUP_CLR_CYC    (SM),
    .PB_PRESS_CYC   (PN),
    .PB_RELEASE_CYC (PM)
  ) u0 (
    .clk        (clk),
    .por_n      (por_n),
    .supply_low (supply_low),
    .btn_n      (btn_n),
    .rst_out    (rst_out),
    .rst_out_n  (rst_out_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive causes edge by edge; record first high edge and first low edge after it.
  task automatic run_case(input int sup_len, input int pb_len, input logic [63:0] gap,
                          input int watch, output int rise, output int fall,
                          output bit comp_ok);
    rise = 0; fall = 0; comp_ok = 1'b1;
    for (int e = 1; e <= watch; e++) begin
      supply_low = (e <= sup_len);
      btn_n = !((e <= pb_len) && !((e < 64) ? gap[e] : 1'b0));
      @(posedge clk); #1;
      if (rst_out_n !== !rst_out) comp_ok = 1'b0;
      if (rst_out === 1'b1 && rise == 0) rise = e;
      else if (rst_out === 1'b0 && rise != 0 && fall == 0) fall = e;
    end
    supply_low = 1'b0;
    btn_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int rise, fall;
    bit cok;

    // R2 R1: power-on state and hold
    repeat (3) @(posedge clk);
    #1;
    check(rst_out === 1'b1 && rst_out_n === 1'b0, "R2 reset while por_n low", rst_out, 1);
    por_n = 1'b1;
    for (int e = 1; e <= HOLD; e++) begin
      @(posedge clk); #1;
      if (e == HOLD - 1) check(rst_out === 1'b1, "R2 still held at HOLD-1", rst_out, 1);
      if (e == HOLD) begin
        check(rst_out === 1'b0, "R2 released at HOLD", rst_out, 0);
        check(rst_out_n === 1'b1, "R1 complement after release", rst_out_n, 1);
      end
    end
    repeat (5) @(posedge clk);
    #1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      run_case(VEC[i].sup_len, VEC[i].pb_len, 64'd0, 100, rise, fall, cok);
      check(rise == VEC[i].exp_rise, $sformatf("R4 R5 vec%0d rise edge", i), rise, VEC[i].exp_rise);
      check(fall == VEC[i].exp_fall, $sformatf("R3 R6 vec%0d fall edge", i), fall, VEC[i].exp_fall);
      check(cok, $sformatf("R1 vec%0d complement", i), cok, 1);
      repeat (4) @(posedge clk);
      #1;
    end

    // R7: release bounce (high on edges 11..13, shorter than PM) does not count
    run_case(0, 15, 64'h0000_0000_0000_3800, 100, rise, fall, cok);
    check(rise == 3 + PN, "R7 bounce rise edge", rise, 3 + PN);
    check(fall == 15 + 2 + PM + HOLD, "R7 hold from last low", fall, 15 + 2 + PM + HOLD);
    repeat (4) @(posedge clk);
    #1;

    // R8: second press during hold restarts without a gap
    run_case(0, 8, 64'd0, 8 + 2 + PM + HOLD/2, rise, fall, cok);
    check(rise == 3 + PN && fall == 0, "R8 first press still held", fall, 0);
    run_case(0, 8, 64'd0, 100, rise, fall, cok);
    check(rise == 1, "R8 no gap at restart", rise, 1);
    check(fall == 8 + 2 + PM + HOLD, "R8 restarted hold", fall, 8 + 2 + PM + HOLD);
    repeat (4) @(posedge clk);
    #1;

    // R9: overlapping causes, supply released last
    run_case(60, 8, 64'd0, 130, rise, fall, cok);
    check(rise == 3 + SN, "R9 rise from earlier filter", rise, 3 + SN);
    check(fall == 60 + 2 + SM + HOLD, "R9 held until supply clears", fall, 60 + 2 + SM + HOLD);
    check(cok, "R1 overlap complement", cok, 1);
    repeat (4) @(posedge clk);
    #1;

    // R9: overlapping causes, button released last
    run_case(10, 30, 64'd0, 100, rise, fall, cok);
    check(fall == 30 + 2 + PM + HOLD, "R9 held until button releases", fall, 30 + 2 + PM + HOLD);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule